// File: doc/BRIEF.md
# Key-guarded flash write controller

This block is the register front end of an embedded flash array. Software reaches it through a simple 32-bit register bus with single-cycle write strobes and a one-cycle read latency. Before any program or erase can start, a two-step key sequence must arm the controller. Depending on the second key, the controller is armed for exactly one operation or for an open-ended run of operations. The run stays open until a closing key is written.

A configuration register holds an erase-enable bit, a sticky error bit and a read-only busy flag. Software first latches a target address. A write to the data register then either programs one half-word at that address or erases the whole 1024-byte page that contains it, depending on erase-enable. The flash array is a behavioural model: programming can only clear bits, erasing sets a page to all ones, and each operation takes a fixed number of cycles set by parameters. The array is inspected through a combinational half-word read port.

Top module: `flash_keyed_ctrl`

## Requirements
- R1: After synchronous reset, the configuration word reads 0, the address register reads 0, the key sequencer is locked and every array half-word reads 0xFFFF.
- R2: The configuration word is readable at offsets 0x00, 0x04 and 0x08. Only erase-enable (bit 18) and the error flag (bit 4) are writable. A write to 0x00 replaces both bits, a write to 0x04 sets the bits given as ones, and a write to 0x08 clears the bits given as ones. Bit 20 cannot be written.
- R3: Writing key 0xA5 and then 0xF1 to offset 0xC0 arms exactly one operation. Once that operation starts, the controller is locked again.
- R4: Writing key 0xA5 and then 0xF2 arms any number of operations, until key 0x5A is written.
- R5: Any key write that is not the expected next step returns the sequencer to locked. This includes a write in the armed states other than 0x5A.
- R6: With erase-enable clear, a write to offset 0xB0 programs the half-word at the address in offset 0xA0. The new cell value is the old value AND bits 15:0 of the written data. Bit 0 of the written address is dropped, and the address reads back half-word aligned.
- R7: With erase-enable set, a write to offset 0xB0 sets every half-word of the 1024-byte page containing the latched address to 0xFFFF. The written data has no effect, and other pages are untouched.
- R8: Busy (bit 20) rises in the cycle after an accepted data write. It stays high for PROG_CYCLES cycles for a program and ERASE_CYCLES cycles for an erase. The array holds the new contents from the cycle busy falls.
- R9: A data write while locked or while busy changes nothing in the array. It sets the error flag, which stays set until software clears it.
- R10: Read data appears on the cycle after a read strobe. Offset 0xA0 returns the latched address; offsets 0xB0, 0xC0 and unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| arr_hw_idx | input | ADDR_W-1 | Half-word index for array inspection |
| arr_rdata | output | 16 | Array half-word at arr_hw_idx |

## Verification
The hardest condition to reach is a data write that arrives while the controller is armed but still busy. It must be rejected and flagged, yet leave a multi-operation window open. The stimulus opens a multi window, starts a long page erase and issues a second data write two cycles later. It then clears the flag and proves the window still accepts a program. Busy length is measured by holding the read strobe on the configuration word for every cycle of the operation. The expected busy pattern is queued ahead of the measurement.

// File: rtl/fkc_pkg.sv
package fkc_pkg;

    // register byte offsets
    localparam logic [7:0] OFS_CFG_RW  = 8'h00;
    localparam logic [7:0] OFS_CFG_SET = 8'h04;
    localparam logic [7:0] OFS_CFG_CLR = 8'h08;
    localparam logic [7:0] OFS_WADDR   = 8'hA0;
    localparam logic [7:0] OFS_WDATA   = 8'hB0;
    localparam logic [7:0] OFS_KEY     = 8'hC0;

    // configuration bit positions
    localparam int BIT_ERR   = 4;
    localparam int BIT_ERASE = 18;
    localparam int BIT_BUSY  = 20;

    // key codes
    localparam logic [31:0] KEY_OPEN  = 32'h0000_00A5;
    localparam logic [31:0] KEY_ONE   = 32'h0000_00F1;
    localparam logic [31:0] KEY_MANY  = 32'h0000_00F2;
    localparam logic [31:0] KEY_CLOSE = 32'h0000_005A;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_PRIMED = 2'd1,
        KS_SINGLE = 2'd2,
        KS_MULTI  = 2'd3
    } key_state_e;

    typedef struct packed {
        logic        erase;
        logic [15:0] data;
    } flash_op_t;

    function automatic key_state_e key_next(key_state_e cur, logic [31:0] val);
        key_state_e nxt;
        nxt = KS_LOCKED;
        case (cur)
            KS_LOCKED: nxt = (val == KEY_OPEN) ? KS_PRIMED : KS_LOCKED;
            KS_PRIMED: begin
                if (val == KEY_ONE)       nxt = KS_SINGLE;
                else if (val == KEY_MANY) nxt = KS_MULTI;
                else                      nxt = KS_LOCKED;
            end
            default:   nxt = KS_LOCKED;
        endcase
        return nxt;
    endfunction

    function automatic logic [31:0] cfg_word(logic erase_en, logic busy, logic err);
        logic [31:0] w;
        w = '0;
        w[BIT_ERASE] = erase_en;
        w[BIT_BUSY]  = busy;
        w[BIT_ERR]   = err;
        return w;
    endfunction

endpackage

// File: rtl/fkc_key_seq.sv
module fkc_key_seq
    import fkc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        key_wr,
    input  logic [31:0] key_val,
    input  logic        op_fire,
    output logic        armed
);

    key_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= KS_LOCKED;
        end else if (key_wr) begin
            state <= key_next(state, key_val);
        end else if (op_fire && state == KS_SINGLE) begin
            state <= KS_LOCKED;
        end
    end

    assign armed = (state == KS_SINGLE) || (state == KS_MULTI);

    // R3: a single-shot arm is consumed by the operation it allows
    assert_single_relock_R3: assert property (@(posedge clk) disable iff (rst)
        (state == KS_SINGLE && op_fire && !key_wr) |=> (state == KS_LOCKED))
        else $error("single arm not consumed");

    // R4: a multi window survives operations and idles
    assert_multi_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (state == KS_MULTI && !key_wr) |=> (state == KS_MULTI))
        else $error("multi window closed without key");

    // R5: wrong second key relocks
    assert_bad_key_locks_R5: assert property (@(posedge clk) disable iff (rst)
        (key_wr && state == KS_PRIMED && key_val != KEY_ONE && key_val != KEY_MANY)
        |=> (state == KS_LOCKED))
        else $error("mismatched key left sequencer open");

endmodule

// File: rtl/fkc_op_timer.sv
module fkc_op_timer
    import fkc_pkg::*;
#(
    parameter int HW_W         = 10,
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  flash_op_t       start_op,
    input  logic [HW_W-1:0] start_hw,
    output logic            busy,
    output logic            done,
    output flash_op_t       done_op,
    output logic [HW_W-1:0] done_hw
);

    localparam int MAXC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt;
    flash_op_t        cur_op;
    logic [HW_W-1:0]  cur_hw;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            cur_op <= '0;
            cur_hw <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            cnt    <= start_op.erase ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
            cur_op <= start_op;
            cur_hw <= start_hw;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign done    = busy && (cnt == '0);
    assign done_op = cur_op;
    assign done_hw = cur_hw;

    // R8: an accepted start raises busy on the next edge
    assert_start_sets_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy)
        else $error("busy did not rise");

    // R8: completion drops busy
    assert_done_clears_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy)
        else $error("busy outlived its count");

    // R8: busy never rises on its own
    assert_idle_stays_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy)
        else $error("spurious busy");

endmodule

// File: rtl/fkc_array_stub.sv
module fkc_array_stub
    import fkc_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  flash_op_t         op,
    input  logic [ADDR_W-2:0] op_hw,
    input  logic [ADDR_W-2:0] rd_hw,
    output logic [15:0]       rd_data
);

    localparam int HW_W    = ADDR_W - 1;
    localparam int N_HW    = 1 << HW_W;
    localparam int PIX_W   = $clog2(PAGE_BYTES) - 1;
    localparam int PAGE_HW = 1 << PIX_W;

    logic [15:0] mem [N_HW];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_HW; i++) begin
                mem[i] <= 16'hFFFF;
            end
        end else if (commit) begin
            if (op.erase) begin
                for (int j = 0; j < PAGE_HW; j++) begin
                    mem[{op_hw[HW_W-1:PIX_W], PIX_W'(j)}] <= 16'hFFFF;
                end
            end else begin
                mem[op_hw] <= mem[op_hw] & op.data;
            end
        end
    end

    assign rd_data = mem[rd_hw];

endmodule

// File: rtl/flash_keyed_ctrl.sv
module flash_keyed_ctrl
    import fkc_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int PAGE_BYTES   = 1024,
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [ADDR_W-2:0] arr_hw_idx,
    output logic [15:0]       arr_rdata
);

    localparam int HW_W = ADDR_W - 1;

    logic            erase_en;
    logic            err;
    logic [HW_W-1:0] wr_hw;
    logic            busy;
    logic            armed;
    logic            done;
    flash_op_t       done_op;
    logic [HW_W-1:0] done_hw;
    flash_op_t       new_op;

    logic key_wr, data_wr, accept, reject;

    assign key_wr  = bus_wr && (bus_addr == OFS_KEY);
    assign data_wr = bus_wr && (bus_addr == OFS_WDATA);
    assign accept  = data_wr && armed && !busy;
    assign reject  = data_wr && !accept;

    assign new_op.erase = erase_en;
    assign new_op.data  = bus_wdata[15:0];

    // configuration and address registers
    always_ff @(posedge clk) begin
        if (rst) begin
            erase_en <= 1'b0;
            err      <= 1'b0;
            wr_hw    <= '0;
        end else begin
            if (reject) begin
                err <= 1'b1;
            end
            if (bus_wr) begin
                case (bus_addr)
                    OFS_CFG_RW: begin
                        erase_en <= bus_wdata[BIT_ERASE];
                        err      <= bus_wdata[BIT_ERR];
                    end
                    OFS_CFG_SET: begin
                        if (bus_wdata[BIT_ERASE]) erase_en <= 1'b1;
                        if (bus_wdata[BIT_ERR])   err      <= 1'b1;
                    end
                    OFS_CFG_CLR: begin
                        if (bus_wdata[BIT_ERASE]) erase_en <= 1'b0;
                        if (bus_wdata[BIT_ERR])   err      <= 1'b0;
                    end
                    OFS_WADDR: wr_hw <= bus_wdata[ADDR_W-1:1];
                    default: ;
                endcase
            end
        end
    end

    // registered read path
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                OFS_CFG_RW, OFS_CFG_SET, OFS_CFG_CLR:
                    bus_rdata <= cfg_word(erase_en, busy, err);
                OFS_WADDR:
                    bus_rdata <= 32'({wr_hw, 1'b0});
                default:
                    bus_rdata <= '0;
            endcase
        end
    end

    fkc_key_seq u_key (
        .clk     (clk),
        .rst     (rst),
        .key_wr  (key_wr),
        .key_val (bus_wdata),
        .op_fire (accept),
        .armed   (armed)
    );

    fkc_op_timer #(
        .HW_W         (HW_W),
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .start_op (new_op),
        .start_hw (wr_hw),
        .busy     (busy),
        .done     (done),
        .done_op  (done_op),
        .done_hw  (done_hw)
    );

    fkc_array_stub #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .commit  (done),
        .op      (done_op),
        .op_hw   (done_hw),
        .rd_hw   (arr_hw_idx),
        .rd_data (arr_rdata)
    );

    // R9: a rejected data write leaves the error flag set
    assert_reject_flags_R9: assert property (@(posedge clk) disable iff (rst)
        reject |=> err)
        else $error("rejected write not flagged");

    // R9: a data write while locked never starts an operation
    assert_locked_no_start_R9: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !armed && !busy) |=> !busy)
        else $error("operation started while locked");

    // R2: the error flag only rises through a reject or a software write
    assert_err_source_R2: assert property (@(posedge clk) disable iff (rst)
        (!err && !reject && !bus_wr) |=> !err)
        else $error("error flag rose by itself");

endmodule

// File: tb/test_flash_keyed_ctrl.sv
`timescale 1ns/1ps
module test_flash_keyed_ctrl;

    localparam int ADDR_W = 11;
    localparam int PROG   = 4;
    localparam int ERASE  = 12;
    localparam logic [31:0] C_ERASE = 32'h0004_0000;
    localparam logic [31:0] C_BUSY  = 32'h0010_0000;
    localparam logic [31:0] C_ERR   = 32'h0000_0010;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [ADDR_W-2:0] arr_hw_idx = '0;
    logic [15:0]       arr_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    flash_keyed_ctrl #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(1024), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)
    ) i_flash_keyed_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .arr_hw_idx(arr_hw_idx), .arr_rdata(arr_rdata)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pop one expected item per read strobe seen at an edge
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("monitor underflow", 32'h1, 32'h0);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_exp(logic [7:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic arr_exp(int byte_addr, logic [15:0] e, string tag);
        @(negedge clk);
        arr_hw_idx = (ADDR_W-1)'(byte_addr >> 1);
        #1;
        chk(tag, 32'(arr_rdata), 32'(e));
    endtask

    // accepted data write followed by a busy trace read every cycle
    task automatic op_trace(logic [31:0] d, int len, logic [31:0] base, string tag);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'hB0; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 8'h00;
        for (int k = 1; k <= len + 1; k++) begin
            exp_q.push_back((k <= len) ? (base | C_BUSY) : base);
            tag_q.push_back(tag);
        end
        repeat (len + 1) @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_exp(8'h00, 32'h0, "R1 config after reset");
        rd_exp(8'hA0, 32'h0, "R1 address after reset");
        arr_exp(0, 16'hFFFF, "R1 array first");
        arr_exp(2046, 16'hFFFF, "R1 array last");

        // R2 config aliases
        wr(8'h00, 32'h0004_0010);
        rd_exp(8'h00, C_ERASE | C_ERR, "R2 plain write");
        wr(8'h08, 32'h0000_0010);
        rd_exp(8'h04, C_ERASE, "R2 clear alias");
        wr(8'h04, 32'h0010_0010);
        rd_exp(8'h08, C_ERASE | C_ERR, "R2 set alias, busy not writable");
        wr(8'h00, 32'hFFFF_FFFF);
        rd_exp(8'h00, C_ERASE | C_ERR, "R2 only writable bits");
        wr(8'h00, 32'h0);
        rd_exp(8'h00, 32'h0, "R2 plain write zero");

        // R9 data write while locked
        wr(8'hA0, 32'h10);
        wr(8'hB0, 32'h0);
        rd_exp(8'h00, C_ERR, "R9 locked write flagged");
        arr_exp(16'h10, 16'hFFFF, "R9 locked write ignored");
        wr(8'h08, C_ERR);

        // R3 single arm, R6 program, R8 busy length
        wr(8'hA0, 32'h11);
        rd_exp(8'hA0, 32'h10, "R6 address aligned");
        wr(8'hC0, 32'hA5);
        wr(8'hC0, 32'hF1);
        op_trace(32'hDEAD_1234, PROG, 32'h0, "R8 program busy trace");
        arr_exp(16'h10, 16'h1234, "R6 program value");
        wr(8'hB0, 32'h0);
        idle(PROG + 2);
        rd_exp(8'h00, C_ERR, "R3 single arm consumed");
        arr_exp(16'h10, 16'h1234, "R3 second write ignored");
        wr(8'h08, C_ERR);

        // R4 multi window, R6 AND behaviour
        wr(8'hC0, 32'hA5);
        wr(8'hC0, 32'hF2);
        op_trace(32'hFF0F, PROG, 32'h0, "R4 multi op one");
        arr_exp(16'h10, 16'h1204, "R6 program ANDs old value");
        wr(8'hA0, 32'h20);
        op_trace(32'hABCD, PROG, 32'h0, "R4 multi op two");
        arr_exp(16'h20, 16'hABCD, "R4 second op landed");
        wr(8'hA0, 32'h402);
        op_trace(32'h0, PROG, 32'h0, "R4 multi op three");
        arr_exp(16'h402, 16'h0000, "R6 page one programmed");

        // R7 erase page zero, R8 erase busy length
        wr(8'h04, C_ERASE);
        wr(8'hA0, 32'h10);
        op_trace(32'h0000_0000, ERASE, C_ERASE, "R8 erase busy trace");
        arr_exp(16'h10, 16'hFFFF, "R7 erased cell");
        arr_exp(16'h20, 16'hFFFF, "R7 erased neighbour");
        arr_exp(16'h3FE, 16'hFFFF, "R7 erased page end");
        arr_exp(16'h402, 16'h0000, "R7 other page untouched");

        // R9 data write while busy, window stays open
        wr(8'hA0, 32'h400);
        wr(8'hB0, 32'h0);
        wr(8'hB0, 32'h0);
        idle(ERASE + 2);
        rd_exp(8'h00, C_ERASE | C_ERR, "R9 busy write flagged");
        arr_exp(16'h402, 16'hFFFF, "R7 page one erased");
        wr(8'h00, 32'h0);
        wr(8'hA0, 32'h30);
        op_trace(32'h5555, PROG, 32'h0, "R4 window open after busy reject");
        arr_exp(16'h30, 16'h5555, "R4 program after busy reject");

        // R4 close with lock key
        wr(8'hC0, 32'h5A);
        wr(8'hB0, 32'h0);
        idle(PROG + 2);
        rd_exp(8'h00, C_ERR, "R4 closed window rejects");
        arr_exp(16'h30, 16'h5555, "R4 closed window leaves array");
        wr(8'h08, C_ERR);

        // R5 mismatched keys
        wr(8'hC0, 32'hA5);
        wr(8'hC0, 32'h33);
        wr(8'hB0, 32'h0);
        idle(PROG + 2);
        rd_exp(8'h00, C_ERR, "R5 bad second key locks");
        wr(8'h08, C_ERR);
        wr(8'hC0, 32'hA5);
        wr(8'hC0, 32'hA5);
        wr(8'hC0, 32'hF1);
        wr(8'hB0, 32'h0);
        idle(PROG + 2);
        rd_exp(8'h00, C_ERR, "R5 repeated open key locks");
        arr_exp(16'h30, 16'h5555, "R5 array unchanged");
        wr(8'h08, C_ERR);
        wr(8'hC0, 32'hA5);
        wr(8'hC0, 32'hF1);
        op_trace(32'h00FF, PROG, 32'h0, "R5 correct sequence after relock");
        arr_exp(16'h30, 16'h0055, "R5 program after relock");

        // R10 read map
        rd_exp(8'hB0, 32'h0, "R10 data register reads zero");
        rd_exp(8'hC0, 32'h0, "R10 key register reads zero");
        rd_exp(8'hA0, 32'h30, "R10 address readback");
        rd_exp(8'h50, 32'h0, "R10 unmapped offset");

        idle(3);
        chk("scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule